// File: doc/BRIEF.md
# Strobe-Captured Seven-Segment Display Latch

This block drives three seven-segment displays from two host-written registers: one single-digit display and two displays of two digits each. The host first writes a byte into a data register, then writes a strobe register. Each strobe write is compared with the previous strobe value. Three bits of the strobe register are capture strobes. When one of them goes from 1 to 0, the current data byte is captured into the display value that bit owns. Each display transforms the byte in its own way before storing it.

The stored values pass through a fixed nibble-to-segment table and come out as five 7-bit segment patterns. Both register writes are single-cycle enables on a shared write-data bus. A display changes only in the cycle after a strobe write that carries a falling edge on its own bit.

Top module: `segStrobeLatch`

## Requirements
- R1: After reset, the data register, the previous strobe value and all three display values are zero, so all five segment outputs show 7'h3F.
- R2: A cycle with `dataWe` high stores `wrData` in the data register. A data write alone never changes any segment output.
- R3: A strobe write captures only on bits that were 1 in the previous strobe value and are 0 in the written value. Every strobe write then becomes the new previous value. Rising bits and bits that stay the same capture nothing.
- R4: A falling edge on strobe bit 3 sets the single digit to (16 minus the low nibble of the data register), kept to 4 bits. A low nibble of 0 therefore shows digit 0, and a low nibble of 1 shows digit F.
- R5: A falling edge on strobe bit 4 sets display A to the bitwise inverse of the data byte. Bits 7:4 of the stored byte go to `segAHi` and bits 3:0 go to `segALo`.
- R6: A falling edge on strobe bit 5 sets display B to the bitwise inverse of the data byte. Bits 7:4 go to `segBHi` and bits 3:0 go to `segBLo`.
- R7: Falling edges on strobe bits 0, 1, 2, 6 and 7 leave every display value unchanged.
- R8: When `dataWe` and `strobeWe` are high in the same cycle, any capture uses the data register value from before that cycle's data write.
- R9: Segment patterns, with bit 0 = segment a through bit 6 = segment g, for digits 0 to F: 3F 06 5B 4F 66 6D 7D 07 7F 6F 58 4C 62 69 78 00. Digit F is blank.
- R10: A single strobe write that falls on several capture bits updates every display it names, all in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| dataWe | input | 1 | Write enable for the data register |
| strobeWe | input | 1 | Write enable for the strobe register |
| wrData | input | 8 | Write data shared by both registers |
| segSingle | output | 7 | Segment pattern of the single digit |
| segAHi | output | 7 | Display A, first digit (high nibble) |
| segALo | output | 7 | Display A, second digit (low nibble) |
| segBHi | output | 7 | Display B, first digit (high nibble) |
| segBLo | output | 7 | Display B, second digit (low nibble) |

## Verification
The capture path is driven with strobe sequences that rise, hold low, fall on one capture bit, fall on all three at once, and fall only on the five bits with no display. Together these separate edge detection from level detection and expose wrong bit-to-display wiring. Data bytes are chosen so that the subtraction, the inversion and the nibble order each give a different pattern. These include low nibbles 0 and 1 for the wrap of the single digit, and a sweep of all sixteen nibbles through display A to check every table entry. One write sets data and strobe in the same cycle, to show that the capture takes the data byte held before that write.

// File: rtl/segStrobeLatchPkg.sv
package segStrobeLatchPkg;

  parameter int DATA_W = 8;
  parameter int NIB_W = 4;
  parameter int SEG_W = 7;
  localparam int DIGITS = 5;

  typedef struct packed {
    logic loadSingle;
    logic loadPairA;
    logic loadPairB;
  } latchCmdT;

  function automatic logic [SEG_W-1:0] nibbleToSeg(input logic [NIB_W-1:0] nib);
    logic [SEG_W-1:0] seg;
    case (nib)
      4'h0: seg = 7'h3F;
      4'h1: seg = 7'h06;
      4'h2: seg = 7'h5B;
      4'h3: seg = 7'h4F;
      4'h4: seg = 7'h66;
      4'h5: seg = 7'h6D;
      4'h6: seg = 7'h7D;
      4'h7: seg = 7'h07;
      4'h8: seg = 7'h7F;
      4'h9: seg = 7'h6F;
      4'hA: seg = 7'h58;
      4'hB: seg = 7'h4C;
      4'hC: seg = 7'h62;
      4'hD: seg = 7'h69;
      4'hE: seg = 7'h78;
      default: seg = 7'h00;
    endcase
    return seg;
  endfunction

endpackage

// File: rtl/segLatchCtrl.sv
module segLatchCtrl
  import segStrobeLatchPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SINGLE_BIT = 3,
  parameter int PAIR_A_BIT = 4,
  parameter int PAIR_B_BIT = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dataWe,
  input  logic          strobeWe,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] dataQ,
  output latchCmdT      cmd
);

  logic [DW-1:0] strobeQ;
  logic [DW-1:0] fallBits;

  // data register: the value seen by a capture is the one held before this edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (dataWe) begin
      dataQ <= wrData;
    end
  end

  // previous strobe value, replaced on every strobe write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeQ <= '0;
    end else if (strobeWe) begin
      strobeQ <= wrData;
    end
  end

  always_comb begin
    fallBits = strobeQ & ~wrData;
    cmd.loadSingle = strobeWe & fallBits[SINGLE_BIT];
    cmd.loadPairA  = strobeWe & fallBits[PAIR_A_BIT];
    cmd.loadPairB  = strobeWe & fallBits[PAIR_B_BIT];
  end

endmodule

// File: rtl/segLatchDatapath.sv
module segLatchDatapath
  import segStrobeLatchPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NW = NIB_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  latchCmdT      cmd,
  input  logic [DW-1:0] dataQ,
  output logic [NW-1:0] singleVal,
  output logic [DW-1:0] pairAVal,
  output logic [DW-1:0] pairBVal
);

  localparam logic [NW:0] SPAN = NW'(1) << NW;

  logic [NW:0]   singleDiff;
  logic [DW-1:0] invData;

  always_comb begin
    singleDiff = SPAN - {1'b0, dataQ[NW-1:0]};
    invData = ~dataQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      singleVal <= '0;
    end else if (cmd.loadSingle) begin
      singleVal <= singleDiff[NW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairAVal <= '0;
    end else if (cmd.loadPairA) begin
      pairAVal <= invData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairBVal <= '0;
    end else if (cmd.loadPairB) begin
      pairBVal <= invData;
    end
  end

endmodule

// File: rtl/segNibbleDecoder.sv
module segNibbleDecoder
  import segStrobeLatchPkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output logic [SEG_W-1:0] seg
);

  always_comb begin
    seg = nibbleToSeg(nib);
  end

endmodule

// File: rtl/segStrobeLatch.sv
module segStrobeLatch
  import segStrobeLatchPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataWe,
  input  logic             strobeWe,
  input  logic [DATA_W-1:0] wrData,
  output logic [SEG_W-1:0] segSingle,
  output logic [SEG_W-1:0] segAHi,
  output logic [SEG_W-1:0] segALo,
  output logic [SEG_W-1:0] segBHi,
  output logic [SEG_W-1:0] segBLo
);

  latchCmdT          cmd;
  logic [DATA_W-1:0] dataQ;
  logic [NIB_W-1:0]  singleVal;
  logic [DATA_W-1:0] pairAVal;
  logic [DATA_W-1:0] pairBVal;
  logic [NIB_W-1:0]  digitNib [DIGITS];
  logic [SEG_W-1:0]  digitSeg [DIGITS];

  segLatchCtrl uCtrl (
    .clk(clk), .rstN(rstN), .dataWe(dataWe), .strobeWe(strobeWe),
    .wrData(wrData), .dataQ(dataQ), .cmd(cmd)
  );

  segLatchDatapath uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .dataQ(dataQ),
    .singleVal(singleVal), .pairAVal(pairAVal), .pairBVal(pairBVal)
  );

  always_comb begin
    digitNib[0] = singleVal;
    digitNib[1] = pairAVal[DATA_W-1:NIB_W];
    digitNib[2] = pairAVal[NIB_W-1:0];
    digitNib[3] = pairBVal[DATA_W-1:NIB_W];
    digitNib[4] = pairBVal[NIB_W-1:0];
  end

  for (genvar d = 0; d < DIGITS; d++) begin : gDigit
    segNibbleDecoder uDec (.nib(digitNib[d]), .seg(digitSeg[d]));
  end

  assign segSingle = digitSeg[0];
  assign segAHi    = digitSeg[1];
  assign segALo    = digitSeg[2];
  assign segBHi    = digitSeg[3];
  assign segBLo    = digitSeg[4];

endmodule

// File: rtl/segStrobeLatchChecker.sv
module segStrobeLatchChecker
  import segStrobeLatchPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              dataWe,
  input logic              strobeWe,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] dataQ,
  input logic [NIB_W-1:0]  singleVal,
  input logic [DATA_W-1:0] pairAVal,
  input logic [DATA_W-1:0] pairBVal
);

  logic [DATA_W-1:0] shadowStrobe;
  logic fall3, fall4, fall5;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowStrobe <= '0;
    else if (strobeWe) shadowStrobe <= wrData;
  end

  always_comb begin
    fall3 = strobeWe && shadowStrobe[3] && !wrData[3];
    fall4 = strobeWe && shadowStrobe[4] && !wrData[4];
    fall5 = strobeWe && shadowStrobe[5] && !wrData[5];
  end

  AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    dataWe |=> dataQ == $past(wrData)); // R2
  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    fall3 |=> (singleVal + $past(dataQ[NIB_W-1:0])) == 4'd0); // R4
  AST_PAIRA_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    fall4 |=> (pairAVal ^ $past(dataQ)) == 8'hFF); // R5
  AST_PAIRB_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    fall5 |=> (pairBVal ^ $past(dataQ)) == 8'hFF); // R6
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !fall3 |=> $stable(singleVal)); // R3
  AST_PAIRA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !fall4 |=> $stable(pairAVal)); // R7
  AST_PAIRB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !fall5 |=> $stable(pairBVal)); // R7
  AST_OLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (fall4 && dataWe) |=> pairAVal == ~$past(dataQ)); // R8

endmodule

bind segStrobeLatch segStrobeLatchChecker uChk (
  .clk(clk), .rstN(rstN), .dataWe(dataWe), .strobeWe(strobeWe),
  .wrData(wrData), .dataQ(dataQ), .singleVal(singleVal),
  .pairAVal(pairAVal), .pairBVal(pairBVal)
);

// File: tb/segStrobeLatch_test.sv
module segStrobeLatch_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataWe = 1'b0;
  logic strobeWe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [6:0] segSingle, segAHi, segALo, segBHi, segBLo;

  always #5 clk = ~clk;

  segStrobeLatch uut (
    .clk(clk), .rstN(rstN), .dataWe(dataWe), .strobeWe(strobeWe),
    .wrData(wrData), .segSingle(segSingle), .segAHi(segAHi),
    .segALo(segALo), .segBHi(segBHi), .segBLo(segBLo)
  );

  typedef struct {
    logic [34:0] exp;
    string tag;
  } itemT;

  itemT sbq[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [6:0] segTab [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                              7'h7F, 7'h6F, 7'h58, 7'h4C, 7'h62, 7'h69, 7'h78, 7'h00};

  // reference model state
  logic [7:0] mData = 8'h00;
  logic [7:0] mStrobe = 8'h00;
  logic [3:0] mSingle = 4'h0;
  logic [7:0] mA = 8'h00;
  logic [7:0] mB = 8'h00;

  function automatic logic [34:0] expected();
    return {segTab[mSingle], segTab[mA[7:4]], segTab[mA[3:0]],
            segTab[mB[7:4]], segTab[mB[3:0]]};
  endfunction

  task automatic pushExp(input string tag);
    itemT it;
    it.exp = expected();
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic drive(input bit dw, input bit sw, input logic [7:0] val, input string tag);
    logic [7:0] fall;
    logic [4:0] diff;
    @(negedge clk);
    dataWe = dw;
    strobeWe = sw;
    wrData = val;
    @(negedge clk);
    dataWe = 1'b0;
    strobeWe = 1'b0;
    if (sw) begin
      fall = mStrobe & ~val;
      diff = 5'd16 - {1'b0, mData[3:0]};
      if (fall[3]) mSingle = diff[3:0];
      if (fall[4]) mA = ~mData;
      if (fall[5]) mB = ~mData;
      mStrobe = val;
    end
    if (dw) mData = val;
    pushExp(tag);
  endtask

  // monitor: compares one expected item per cycle, after outputs settle
  always @(negedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      itemT it;
      logic [34:0] act;
      it = sbq.pop_front();
      act = {segSingle, segAHi, segALo, segBHi, segBLo};
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    pushExp("R1 reset state");
    @(negedge clk);
    // R2: data write alone changes nothing
    drive(1, 0, 8'hA5, "R2 data write only");
    // R3: rising edges only
    drive(0, 1, 8'h38, "R3 rising edges capture nothing");
    // R10: all three fall together
    drive(0, 1, 8'h00, "R10 three falls at once");
    drive(0, 1, 8'h00, "R3 steady low no capture");
    // R5: display A
    drive(1, 0, 8'h3C, "R2 data write only");
    drive(0, 1, 8'h10, "R3 rising bit4");
    drive(0, 1, 8'h00, "R5 falling bit4 loads A");
    // R7: non-capture bits
    drive(1, 0, 8'h12, "R2 data write only");
    drive(0, 1, 8'hC7, "R7 rise on unused bits");
    drive(0, 1, 8'h00, "R7 fall on unused bits");
    // R6: display B
    drive(0, 1, 8'h20, "R3 rising bit5");
    drive(1, 0, 8'h0F, "R2 data write only");
    drive(0, 1, 8'h00, "R6 falling bit5 loads B");
    // R4 boundaries
    drive(1, 0, 8'h50, "R2 data write only");
    drive(0, 1, 8'h08, "R3 rising bit3");
    drive(0, 1, 8'h00, "R4 low nibble 0 gives digit 0");
    drive(1, 0, 8'h71, "R2 data write only");
    drive(0, 1, 8'h08, "R3 rising bit3");
    drive(0, 1, 8'h00, "R4 low nibble 1 gives digit F");
    drive(1, 0, 8'h03, "R2 data write only");
    drive(0, 1, 8'h08, "R3 rising bit3");
    drive(0, 1, 8'h00, "R4 low nibble 3 gives digit D");
    // R8: simultaneous write uses old data
    drive(1, 0, 8'h96, "R2 data write only");
    drive(0, 1, 8'h10, "R3 rising bit4");
    drive(1, 1, 8'h00, "R8 capture uses data before same-cycle write");
    drive(0, 1, 8'h10, "R3 rising bit4");
    drive(0, 1, 8'h00, "R8 later capture sees new data");
    // R9: every table entry through display A
    for (int n = 0; n < 16; n++) begin
      drive(1, 0, ~{n[3:0], n[3:0]}, "R2 data write only");
      drive(0, 1, 8'h10, "R3 rising bit4");
      drive(0, 1, 8'h00, "R9 segment table entry");
    end
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule